// File: doc/BRIEF.md
# Cascaded Microsecond Deadline Timer

This block keeps a 32-bit microsecond timebase built from two chained 16-bit up-counters. A prescaler divides the core clock down to one tick per microsecond; each tick advances the low half, and every time the low half rolls over from its all-ones value to zero the high half advances by one. A rollover of the high half raises an overflow flag, so software can extend the count past 32 bits.

A deadline unit can be armed with a 32-bit deadline. The arming rule looks at the upper 16 bits of the deadline against the live high count:
- equal: the unit goes straight to the low-half comparison;
- greater: the unit first waits for the high half, then moves to the low-half comparison;
- lower: the request changes nothing except the recorded deadline.

When the count equals the deadline, a match flag is set and, while the match is enabled, the interrupt output rises.

Reading the full count goes through a small snapshot sequencer. It samples the high half, then the low half, then the high half again. It starts over whenever the two high samples differ, so the returned word never mixes halves from either side of a low-half rollover.

Deadline unit states and transitions:
- `DL_IDLE` goes to `DL_WAIT_LO` on an arm with an equal upper half.
- `DL_IDLE` goes to `DL_WAIT_HI` on an arm with a greater upper half.
- `DL_WAIT_HI` goes to `DL_WAIT_LO` when the high half reaches its compare value.
- `DL_WAIT_HI` goes directly to `DL_IDLE` with a match when both halves already equal the deadline.
- `DL_WAIT_LO` goes to `DL_IDLE` with a match when the full count equals the deadline.
- Any state goes to `DL_IDLE` on a disarm.
- Any valid arm re-enters the state its upper half selects.

Snapshot sequencer states and transitions:
- `RD_IDLE` goes to `RD_HI1` on a read request.
- `RD_HI1` samples the high half and goes to `RD_LO`.
- `RD_LO` samples the low half and goes to `RD_HI2`.
- `RD_HI2` returns to `RD_IDLE` with valid data when the high half is unchanged.
- `RD_HI2` goes back to `RD_HI1` (retry) when the high half has changed.

Top module: `usec_deadline_timer`

## Requirements
- R1: After reset both halves, all flags, the recorded deadline and the interrupt are zero. While `count_en` is high the low half advances by exactly one every `CLK_PER_US` clocks. While `count_en` is low the count holds.
- R2: The low half steps from 0xFFFF to 0x0000 and, in the same clock, adds one to the high half. The high half changes on no other tick.
- R3: A `load_start` pulse writes `start_val[31:16]` into the high half and `start_val[15:0]` into the low half. It also restarts the prescaler phase, so the next increment comes `CLK_PER_US` enabled clocks after the load edge.
- R4: When the high half steps from 0xFFFF to 0x0000, `ovf_flag` is set and `irq` rises.
- R5: An arm whose deadline upper half equals the current high half sets `match_flag` one clock after the count first equals the deadline, and not earlier.
- R6: An arm whose deadline upper half is greater than the current high half waits for the high half to match, then for the low half. This includes a deadline with a low half of 0x0000 reached through a low-half rollover.
- R7: An arm whose deadline upper half is below the current high half leaves the deadline unit as it was, including any earlier arming still in progress.
- R8: Every arm updates `last_deadline`. A valid arm (upper half equal or greater) also clears `match_flag`.
- R9: A `disarm` pulse cancels a pending match, removes the match from `irq`, and leaves `last_deadline` unchanged.
- R10: A single `clr_status` pulse clears both `match_flag` and `ovf_flag`.
- R11: A `rd_req` pulse returns `{high, low}` on a one-clock `rd_valid`. The high half is taken before and after the low half, and the read retries until both high samples agree.
- R12: `irq` is high while `ovf_flag` is set, or while `match_flag` is set and the match is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_en | input | 1 | Enables the prescaler and therefore counting |
| load_start | input | 1 | One-clock pulse: overwrite the count with `start_val` |
| start_val | input | 32 | Start count (upper half to high counter, lower half to low counter) |
| arm | input | 1 | One-clock pulse: arm the deadline unit with `deadline` |
| deadline | input | 32 | Deadline value for an arm |
| disarm | input | 1 | One-clock pulse: cancel the deadline and mask its interrupt |
| clr_status | input | 1 | One-clock pulse: clear match and overflow flags |
| rd_req | input | 1 | One-clock pulse: start a coherent read |
| rd_busy | output | 1 | Snapshot sequencer is running |
| rd_valid | output | 1 | One-clock strobe: `rd_data` holds a coherent count |
| rd_data | output | 32 | Coherent 32-bit count |
| last_deadline | output | 32 | Deadline of the most recent arm request |
| match_flag | output | 1 | Deadline reached |
| ovf_flag | output | 1 | High counter wrapped |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every clock:
- the prescaler never ticks on two clocks in a row;
- the low half rolls to zero and carries into the high half;
- the high half holds unless a rollover or load occurs;
- a load lands both halves;
- an overflow pulse coincides with the high half wrapping;
- a rising match flag always follows a clock in which the count equalled the compare value;
- a below-current arm leaves the state untouched;
- disarm and clear take effect on the next clock;
- returned read data carries the high half present at the final sample.

Other behaviour only the bench scenarios can show, because it depends on the exact number of enabled clocks:
- the divide ratio;
- the restart of the prescaler phase on a load;
- a match that arrives neither a tick early nor late in the equal, greater and low-zero cases;
- an earlier arming surviving a past-deadline request;
- reads started at every offset around a low-half rollover never returning a torn word.

// File: rtl/utimer_pkg.sv
package utimer_pkg;

    typedef enum logic [1:0] {
        DL_IDLE    = 2'd0,
        DL_WAIT_HI = 2'd1,
        DL_WAIT_LO = 2'd2
    } dl_state_e;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_HI1  = 2'd1,
        RD_LO   = 2'd2,
        RD_HI2  = 2'd3
    } rd_state_e;

endpackage

// File: rtl/utimer_prescale.sv
module utimer_prescale #(
    parameter int DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic restart_i,
    output logic tick_o
);

    generate
        if (DIV > 1) begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    phase_q <= '0;
                end else if (restart_i) begin
                    phase_q <= '0;
                end else if (en_i) begin
                    phase_q <= (phase_q == LAST) ? '0 : phase_q + PW'(1);
                end
            end

            assign tick_o = en_i && !restart_i && (phase_q == LAST);

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R1
        end else begin : g_pass
            assign tick_o = en_i && !restart_i;
        end
    endgenerate

endmodule

// File: rtl/utimer_cascade.sv
module utimer_cascade #(
    parameter int HALF_W = 16,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [FULL_W-1:0] load_val_i,
    output logic [HALF_W-1:0] hi_o,
    output logic [HALF_W-1:0] lo_o,
    output logic              ovf_o
);

    localparam logic [HALF_W-1:0] TOP = '1;

    logic [HALF_W-1:0] hi_q, lo_q;
    logic              ovf_q;
    logic              lo_roll;

    assign lo_roll = tick_i && (lo_q == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (load_i) begin
                hi_q <= load_val_i[FULL_W-1:HALF_W];
                lo_q <= load_val_i[HALF_W-1:0];
            end else if (tick_i) begin
                lo_q <= lo_q + HALF_W'(1);
                if (lo_roll) begin
                    hi_q  <= hi_q + HALF_W'(1);
                    ovf_q <= (hi_q == TOP);
                end
            end
        end
    end

    assign hi_o  = hi_q;
    assign lo_o  = lo_q;
    assign ovf_o = ovf_q;

    AST_LO_ROLL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && lo_roll) |=> (lo_q == '0) && (hi_q == $past(hi_q) + HALF_W'(1))); // R2
    AST_HI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !lo_roll) |=> $stable(hi_q)); // R2
    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ({hi_q, lo_q} == $past(load_val_i))); // R3
    AST_NO_OVERFLOW_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && lo_roll && hi_q == TOP) |=> (ovf_o && hi_q == '0)); // R4

endmodule

// File: rtl/utimer_deadline.sv
module utimer_deadline
    import utimer_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] hi_i,
    input  logic [HALF_W-1:0] lo_i,
    input  logic              ovf_i,
    input  logic              arm_i,
    input  logic [FULL_W-1:0] deadline_i,
    input  logic              disarm_i,
    input  logic              clr_i,
    output logic              match_o,
    output logic              ovf_flag_o,
    output logic              irq_o,
    output logic [FULL_W-1:0] last_dl_o
);

    dl_state_e         state_q, state_d;
    logic [HALF_W-1:0] cmp_hi_q, cmp_lo_q;
    logic              match_ie_q, match_flag_q, ovf_flag_q;
    logic [FULL_W-1:0] last_dl_q;

    logic [HALF_W-1:0] dl_hi;
    logic              arm_eq, arm_gt, arm_ok, hi_hit, lo_hit, fire;

    assign dl_hi  = deadline_i[FULL_W-1:HALF_W];
    assign arm_eq = arm_i && (dl_hi == hi_i);
    assign arm_gt = arm_i && (dl_hi > hi_i);
    assign arm_ok = !disarm_i && (arm_eq || arm_gt);
    assign hi_hit = (hi_i == cmp_hi_q);
    assign lo_hit = (lo_i == cmp_lo_q);

    // next-state logic
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            DL_IDLE: ;
            DL_WAIT_HI: begin
                if (hi_hit) begin
                    if (lo_hit) begin
                        fire    = 1'b1;
                        state_d = DL_IDLE;
                    end else begin
                        state_d = DL_WAIT_LO;
                    end
                end
            end
            DL_WAIT_LO: begin
                if (hi_hit && lo_hit) begin
                    fire    = 1'b1;
                    state_d = DL_IDLE;
                end
            end
            default: state_d = DL_IDLE;
        endcase
        if (disarm_i) begin
            state_d = DL_IDLE;
            fire    = 1'b0;
        end else if (arm_eq) begin
            state_d = DL_WAIT_LO;
            fire    = 1'b0;
        end else if (arm_gt) begin
            state_d = DL_WAIT_HI;
            fire    = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DL_IDLE;
        else        state_q <= state_d;
    end

    // outputs and compare registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_hi_q     <= '0;
            cmp_lo_q     <= '0;
            match_ie_q   <= 1'b0;
            match_flag_q <= 1'b0;
            ovf_flag_q   <= 1'b0;
            last_dl_q    <= '0;
        end else begin
            if (arm_i) last_dl_q <= deadline_i;
            if (arm_ok) begin
                cmp_hi_q <= dl_hi;
                cmp_lo_q <= deadline_i[HALF_W-1:0];
            end
            if (disarm_i)    match_ie_q <= 1'b0;
            else if (arm_ok) match_ie_q <= 1'b1;
            if (fire)                  match_flag_q <= 1'b1;
            else if (clr_i || arm_ok)  match_flag_q <= 1'b0;
            if (ovf_i)      ovf_flag_q <= 1'b1;
            else if (clr_i) ovf_flag_q <= 1'b0;
        end
    end

    assign match_o    = match_flag_q;
    assign ovf_flag_o = ovf_flag_q;
    assign irq_o      = (match_flag_q && match_ie_q) || ovf_flag_q;
    assign last_dl_o  = last_dl_q;

    AST_MATCH_ON_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag_q) |-> ($past({hi_i, lo_i}) == $past({cmp_hi_q, cmp_lo_q}))); // R5
    AST_PAST_ARM_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_i && !disarm_i && (dl_hi < hi_i)) |=> (state_q == $past(state_q))); // R7
    AST_ARM_CLEARS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        arm_ok |=> !match_flag_q); // R8
    AST_DISARM_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        disarm_i |=> (state_q == DL_IDLE) && !(match_flag_q && match_ie_q)); // R9
    AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !ovf_i && !fire) |=> (!ovf_flag_q && !match_flag_q)); // R10

endmodule

// File: rtl/utimer_snapshot.sv
module utimer_snapshot
    import utimer_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_i,
    input  logic [HALF_W-1:0] hi_i,
    input  logic [HALF_W-1:0] lo_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [FULL_W-1:0] data_o
);

    rd_state_e         rd_q, rd_d;
    logic [HALF_W-1:0] hi_s_q, lo_s_q;
    logic              valid_q;
    logic [FULL_W-1:0] data_q;
    logic              same_hi;

    assign same_hi = (hi_i == hi_s_q);

    // next-state logic
    always_comb begin
        rd_d = rd_q;
        unique case (rd_q)
            RD_IDLE: if (rd_req_i) rd_d = RD_HI1;
            RD_HI1:  rd_d = RD_LO;
            RD_LO:   rd_d = RD_HI2;
            RD_HI2:  rd_d = same_hi ? RD_IDLE : RD_HI1;
            default: rd_d = RD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= RD_IDLE;
        else        rd_q <= rd_d;
    end

    // sample and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_s_q  <= '0;
            lo_s_q  <= '0;
            valid_q <= 1'b0;
            data_q  <= '0;
        end else begin
            valid_q <= 1'b0;
            if (rd_q == RD_HI1) hi_s_q <= hi_i;
            if (rd_q == RD_LO)  lo_s_q <= lo_i;
            if (rd_q == RD_HI2 && same_hi) begin
                data_q  <= {hi_s_q, lo_s_q};
                valid_q <= 1'b1;
            end
        end
    end

    assign busy_o  = (rd_q != RD_IDLE);
    assign valid_o = valid_q;
    assign data_o  = data_q;

    AST_READ_HI_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (data_o[FULL_W-1:HALF_W] == $past(hi_i))); // R11
    AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R11

endmodule

// File: rtl/usec_deadline_timer.sv
module usec_deadline_timer #(
    parameter int CLK_PER_US = 200,
    parameter int HALF_W     = 16,
    localparam int FULL_W    = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_en,
    input  logic              load_start,
    input  logic [FULL_W-1:0] start_val,
    input  logic              arm,
    input  logic [FULL_W-1:0] deadline,
    input  logic              disarm,
    input  logic              clr_status,
    input  logic              rd_req,
    output logic              rd_busy,
    output logic              rd_valid,
    output logic [FULL_W-1:0] rd_data,
    output logic [FULL_W-1:0] last_deadline,
    output logic              match_flag,
    output logic              ovf_flag,
    output logic              irq
);

    logic              tick;
    logic [HALF_W-1:0] hi_cnt, lo_cnt;
    logic              hi_wrap;

    utimer_prescale #(.DIV(CLK_PER_US)) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (count_en),
        .restart_i (load_start),
        .tick_o    (tick)
    );

    utimer_cascade #(.HALF_W(HALF_W)) u_cascade (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (load_start),
        .load_val_i (start_val),
        .hi_o       (hi_cnt),
        .lo_o       (lo_cnt),
        .ovf_o      (hi_wrap)
    );

    utimer_deadline #(.HALF_W(HALF_W)) u_deadline (
        .clk        (clk),
        .rst_n      (rst_n),
        .hi_i       (hi_cnt),
        .lo_i       (lo_cnt),
        .ovf_i      (hi_wrap),
        .arm_i      (arm),
        .deadline_i (deadline),
        .disarm_i   (disarm),
        .clr_i      (clr_status),
        .match_o    (match_flag),
        .ovf_flag_o (ovf_flag),
        .irq_o      (irq),
        .last_dl_o  (last_deadline)
    );

    utimer_snapshot #(.HALF_W(HALF_W)) u_snapshot (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req_i (rd_req),
        .hi_i     (hi_cnt),
        .lo_i     (lo_cnt),
        .busy_o   (rd_busy),
        .valid_o  (rd_valid),
        .data_o   (rd_data)
    );

    AST_IRQ_FOLLOWS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> irq); // R12

endmodule

// File: tb/usec_deadline_timer_bench.sv
`timescale 1ns/1ps
module usec_deadline_timer_bench;

    localparam int DIV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_en = 1'b0, load_start = 1'b0, arm = 1'b0;
    logic        disarm = 1'b0, clr_status = 1'b0, rd_req = 1'b0;
    logic [31:0] start_val = '0, deadline = '0;
    logic        rd_busy, rd_valid, match_flag, ovf_flag, irq;
    logic [31:0] rd_data, last_deadline;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    usec_deadline_timer #(.CLK_PER_US(DIV)) u_usec_deadline_timer (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .load_start(load_start),
        .start_val(start_val), .arm(arm), .deadline(deadline), .disarm(disarm),
        .clr_status(clr_status), .rd_req(rd_req), .rd_busy(rd_busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .last_deadline(last_deadline),
        .match_flag(match_flag), .ovf_flag(ovf_flag), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic do_load(input logic [31:0] v);
        @(negedge clk); load_start = 1'b1; start_val = v;
        @(negedge clk); load_start = 1'b0;
    endtask

    task automatic do_arm(input logic [31:0] v);
        @(negedge clk); arm = 1'b1; deadline = v;
        @(negedge clk); arm = 1'b0;
    endtask

    task automatic do_disarm();
        @(negedge clk); disarm = 1'b1;
        @(negedge clk); disarm = 1'b0;
    endtask

    task automatic do_clr();
        @(negedge clk); clr_status = 1'b1;
        @(negedge clk); clr_status = 1'b0;
    endtask

    task automatic run_edges(input int n);
        @(negedge clk); count_en = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk); count_en = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        run_edges(n * DIV);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_read(output logic [31:0] v);
        bit got = 0;
        v = 'x;
        @(negedge clk); rd_req = 1'b1;
        @(negedge clk); rd_req = 1'b0;
        for (int i = 0; i < 40 && !got; i++) begin
            @(negedge clk);
            if (rd_valid) begin
                v = rd_data;
                got = 1;
            end
        end
    endtask

    // R1 reset state
    task automatic t_reset();
        logic [31:0] v;
        chk("R1", "match after reset", 32'(match_flag), 0);
        chk("R1", "ovf after reset", 32'(ovf_flag), 0);
        chk("R1", "irq after reset", 32'(irq), 0);
        chk("R1", "last deadline after reset", last_deadline, 0);
        do_read(v);
        chk("R1", "count after reset", v, 0);
    endtask

    // R1 divide ratio and hold, R3 load and phase restart
    task automatic t_prescale();
        logic [31:0] v;
        do_load(32'h0000_1230);
        repeat (20) @(negedge clk);
        do_read(v);
        chk("R3", "count after load, disabled", v, 32'h0000_1230);
        run_edges(10 * DIV);
        do_read(v);
        chk("R1", "ten ticks after 10*DIV clocks", v, 32'h0000_123A);
        run_edges(3);
        @(negedge clk); count_en = 1'b1; load_start = 1'b1; start_val = 32'h0000_5550;
        @(negedge clk); load_start = 1'b0;
        repeat (DIV - 1) @(posedge clk);
        @(negedge clk); count_en = 1'b0;
        do_read(v);
        chk("R3", "no tick within DIV clocks of load", v, 32'h0000_5550);
        run_edges(1);
        do_read(v);
        chk("R3", "tick on DIV-th clock after load", v, 32'h0000_5551);
    endtask

    // R2 carry into the high half
    task automatic t_carry();
        logic [31:0] v;
        do_load(32'h0001_FFFF);
        run_edges(DIV - 1);
        do_read(v);
        chk("R2", "before rollover", v, 32'h0001_FFFF);
        run_edges(1);
        do_read(v);
        chk("R2", "rollover carries into high half", v, 32'h0002_0000);
    endtask

    // R5 equal upper half, R8 arm clears, R9 and R12 masking
    task automatic t_match_equal();
        logic [31:0] v;
        do_load(32'h0005_0000);
        do_clr();
        do_arm(32'h0005_0003);
        chk("R8", "last deadline after arm", last_deadline, 32'h0005_0003);
        run_ticks(2);
        chk("R5", "no match one tick early", 32'(match_flag), 0);
        run_ticks(1);
        chk("R5", "match at deadline", 32'(match_flag), 1);
        chk("R12", "irq with enabled match", 32'(irq), 1);
        do_read(v);
        chk("R5", "count at match", v, 32'h0005_0003);
        do_disarm();
        chk("R9", "disarm masks irq", 32'(irq), 0);
        chk("R12", "flag stays after disarm", 32'(match_flag), 1);
        do_arm(32'h0005_0010);
        chk("R8", "valid arm clears match flag", 32'(match_flag), 0);
        do_disarm();
    endtask

    // R6 greater upper half, including low half of zero
    task automatic t_match_greater();
        logic [31:0] v;
        do_load(32'h0003_FFFE);
        do_clr();
        do_arm(32'h0004_0001);
        run_ticks(2);
        chk("R6", "high stage met, low not yet", 32'(match_flag), 0);
        run_ticks(1);
        chk("R6", "two-stage match", 32'(match_flag), 1);
        do_read(v);
        chk("R6", "count at two-stage match", v, 32'h0004_0001);
        do_disarm(); do_clr();
        do_load(32'h0006_FFFE);
        do_arm(32'h0007_0000);
        run_ticks(1);
        chk("R6", "no match before low-zero deadline", 32'(match_flag), 0);
        run_ticks(1);
        chk("R6", "match on low-zero deadline", 32'(match_flag), 1);
        do_read(v);
        chk("R6", "count at low-zero deadline", v, 32'h0007_0000);
        do_disarm(); do_clr();
    endtask

    // R7 deadline below current high half
    task automatic t_past();
        logic [31:0] v;
        do_load(32'h0010_0000);
        do_arm(32'h0010_0004);
        do_arm(32'h000F_0000);
        chk("R7", "last deadline records ignored arm", last_deadline, 32'h000F_0000);
        run_ticks(4);
        chk("R7", "earlier arming survives", 32'(match_flag), 1);
        do_read(v);
        chk("R7", "count at surviving match", v, 32'h0010_0004);
        do_disarm(); do_clr();
        do_arm(32'h000F_1234);
        run_ticks(4);
        chk("R7", "past arm alone: no match", 32'(match_flag), 0);
        chk("R7", "past arm alone: no irq", 32'(irq), 0);
    endtask

    // R9 disarm before deadline
    task automatic t_disarm();
        do_load(32'h0020_0000);
        do_clr();
        do_arm(32'h0020_0002);
        do_disarm();
        run_ticks(3);
        chk("R9", "no match after disarm", 32'(match_flag), 0);
        chk("R9", "no irq after disarm", 32'(irq), 0);
        chk("R9", "last deadline kept", last_deadline, 32'h0020_0002);
    endtask

    // R4 overflow, R10 single clear
    task automatic t_overflow();
        logic [31:0] v;
        do_load(32'hFFFF_FFFE);
        do_clr();
        do_arm(32'hFFFF_FFFF);
        run_ticks(1);
        chk("R5", "match at all-ones", 32'(match_flag), 1);
        chk("R4", "no overflow yet", 32'(ovf_flag), 0);
        run_ticks(1);
        chk("R4", "overflow flag", 32'(ovf_flag), 1);
        chk("R4", "overflow irq", 32'(irq), 1);
        do_read(v);
        chk("R4", "count after 32-bit wrap", v, 0);
        do_clr();
        chk("R10", "match cleared", 32'(match_flag), 0);
        chk("R10", "overflow cleared", 32'(ovf_flag), 0);
        chk("R10", "irq low after clear", 32'(irq), 0);
        do_disarm();
    endtask

    // R11 reads started at every offset around a low rollover
    task automatic t_coherent();
        logic [31:0] v;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); count_en = 1'b1; load_start = 1'b1; start_val = 32'h0001_FFFF;
            @(negedge clk); load_start = 1'b0;
            repeat (k) @(negedge clk);
            do_read(v);
            count_en = 1'b0;
            n_checks++;
            if (v !== 32'h0001_FFFF && v !== 32'h0002_0000 && v !== 32'h0002_0001) begin
                n_fail++;
                $display("FAIL R11 offset %0d: actual=%h expected=0001ffff/00020000/00020001", k, v);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_prescale();
        t_carry();
        t_match_equal();
        t_match_greater();
        t_past();
        t_disarm();
        t_overflow();
        t_coherent();
        finish_run();
    end

endmodule